// File: doc/BRIEF.md
# Multi-Mode Baud Rate Generator

This block divides the system clock into a one-cycle baud tick for a serial transmitter and receiver. It also produces a finer sub-tick that a receiver can use for oversampling. Software loads a divisor `n` as two byte-wide writes, one for the upper byte and one for the lower byte. Three level controls then select the overall division factor M*(n+1), where M is 64, 16 or 4.

The block is built as two counters. A down-counter runs from `n` to 0 and reloads. Each reload produces one sub-tick. A prescale counter counts M sub-ticks and produces the baud tick on the last one.

Any write to a divisor byte, or any change of a mode control, restarts both counters. The new rate therefore starts from a clean phase. The block does not wait for the old period to finish.

Top module: `baud_gen_top`

## Requirements
- R1: While `rst_n` is low, both ticks are low. Reset clears the divisor and the mode. After release with no writes, the sub-tick is first high in the first cycle after the first rising edge that samples `rst_n` high. The baud tick is first high in the 64th such cycle and then repeats every 64 cycles.
- R2: When `wide_sel` is 0, the divisor is the lower byte alone, and the value in the upper byte has no effect on either tick.
- R3: When `wide_sel` is 1, the divisor is the 16-bit value {upper byte, lower byte}.
- R4: With `sync_sel`=0, `wide_sel`=0 and `fast_sel`=0, the baud period is 64*(n+1) clocks.
- R5: With `sync_sel`=0 and exactly one of `wide_sel` and `fast_sel` set, the baud period is 16*(n+1) clocks.
- R6: With `sync_sel`=0, `wide_sel`=1 and `fast_sel`=1, the baud period is 4*(n+1) clocks.
- R7: With `sync_sel`=1, the baud period is 4*(n+1) clocks for either value of `wide_sel`, and `fast_sel` has no effect.
- R8: A write to either divisor byte in cycle 0 restarts the timer at once. The sub-tick is first high in cycle n+2 and the baud tick in cycle M*(n+1)+1, whatever the phase was before the write.
- R9: A change of any mode control sampled in cycle 0 restarts the timer with the same latency as a divisor write, now using the new M.
- R10: Consecutive sub-ticks are n+1 clocks apart. With n=0 the sub-tick is high in every cycle.
- R11: The baud tick is a single-cycle pulse, and it is high only in cycles where the sub-tick is also high.
- R12: For a 16 MHz clock with `sync_sel`=0, `wide_sel`=0, `fast_sel`=0 and n=25, the baud period of 1664 clocks gives a rate of 9615 ticks per second, in integer arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_hi | input | 1 | Write strobe for the upper divisor byte |
| wr_lo | input | 1 | Write strobe for the lower divisor byte |
| wr_data | input | BYTE_W | Byte written by either strobe |
| sync_sel | input | 1 | Synchronous mode select (forces M=4) |
| wide_sel | input | 1 | Use the full 16-bit divisor |
| fast_sel | input | 1 | High-speed select, asynchronous mode only |
| baud_tick | output | 1 | One-cycle pulse every M*(n+1) clocks |
| sub_tick | output | 1 | One-cycle pulse every n+1 clocks |

## Verification
The bench sweeps all eight combinations of the three mode controls. For each combination it uses lower bytes 0, 1, 2, 7 and 25 with upper bytes 0 and 1.

For each setting it measures three things: the first-tick latency from the restarting write, the sub-tick spacing and the baud period. These measurements separate the three prescale factors. They also show whether the upper byte is ignored (narrow mode) or used (wide mode), and whether `fast_sel` is dropped in synchronous mode.

Separate runs restart the timer in mid-period, once by rewriting an unchanged divisor and once by flipping a mode control. A timer that waits for the old overflow then shows a first baud tick in the wrong cycle. The n=0 cases show a sub-tick in every cycle.

// File: rtl/brg_pkg.sv
package brg_pkg;

    // Prescale counter width: holds up to 64 sub-ticks
    localparam int PRE_W     = 6;
    // Width of the log2 prescale selector
    localparam int PRE_LOG_W = 3;

    typedef struct packed {
        logic sync_sel;
        logic wide_sel;
        logic fast_sel;
    } brg_mode_t;

    // log2 of the prescale factor M for a mode combination
    function automatic logic [PRE_LOG_W-1:0] prescale_log2(brg_mode_t m);
        logic [PRE_LOG_W-1:0] r;
        if (m.sync_sel) begin
            r = PRE_LOG_W'(2);
        end else begin
            case ({m.wide_sel, m.fast_sel})
                2'b00:   r = PRE_LOG_W'(6);
                2'b11:   r = PRE_LOG_W'(2);
                default: r = PRE_LOG_W'(4);
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/brg_cfg_regs.sv
module brg_cfg_regs
    import brg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [BYTE_W-1:0]     wr_data,
    input  brg_mode_t             mode_in,
    output logic [2*BYTE_W-1:0]   div_n,
    output brg_mode_t             mode_q_o,
    output logic                  restart_o
);

    localparam int NUM_BYTES = 2;
    localparam int DIV_W     = NUM_BYTES * BYTE_W;

    typedef struct packed {
        logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes;
        brg_mode_t                        mode;
        logic                             restart;
    } cfg_t;

    localparam cfg_t CFG_RST = '{bytes: '0, mode: '0, restart: 1'b1};

    cfg_t cfg_d, cfg_q;
    logic [NUM_BYTES-1:0] wr_en;

    assign wr_en = {wr_hi, wr_lo};

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (wr_en[i]) begin
                cfg_d.bytes[i] = wr_data;
            end
        end
        cfg_d.mode    = mode_in;
        cfg_d.restart = (|wr_en) || (mode_in != cfg_q.mode);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Narrow counting uses the lower byte only
    always_comb begin
        if (cfg_q.mode.wide_sel) begin
            div_n = DIV_W'(cfg_q.bytes);
        end else begin
            div_n = DIV_W'(cfg_q.bytes[0]);
        end
    end

    assign mode_q_o  = cfg_q.mode;
    assign restart_o = cfg_q.restart;

    AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi || wr_lo) |=> restart_o); // R8

    AST_MODE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in != mode_q_o) |=> restart_o); // R9

endmodule

// File: rtl/brg_sub_counter.sv
module brg_sub_counter #(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DIV_W-1:0]  reload,
    output logic              sub_tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } sub_state_t;

    sub_state_t st_d, st_q;
    logic       at_zero;

    always_comb begin
        st_d     = st_q;
        at_zero  = (st_q.cnt == '0);
        sub_tick = at_zero && !restart;
        if (restart || at_zero) begin
            st_d.cnt = reload;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (st_q.cnt <= reload)); // R10

    AST_SUB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_tick && reload != '0) |=> !sub_tick); // R10

endmodule

// File: rtl/brg_prescaler.sv
module brg_prescaler
    import brg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic                  sub_tick,
    input  logic [PRE_LOG_W-1:0]  pre_log2,
    output logic                  baud_tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t      st_d, st_q;
    logic [PRE_W-1:0] terminal;
    logic             at_end;

    always_comb begin
        st_d      = st_q;
        terminal  = ~({PRE_W{1'b1}} << pre_log2);
        at_end    = (st_q.pre == terminal);
        baud_tick = sub_tick && at_end;
        if (restart) begin
            st_d.pre = '0;
        end else if (sub_tick) begin
            st_d.pre = at_end ? '0 : st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (st_q.pre <= terminal)); // R4

    AST_BAUD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick); // R11

endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
    import brg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              sync_sel,
    input  logic              wide_sel,
    input  logic              fast_sel,
    output logic              baud_tick,
    output logic              sub_tick
);

    localparam int DIV_W = 2 * BYTE_W;

    brg_mode_t            mode_in;
    brg_mode_t            mode_q;
    logic [DIV_W-1:0]     div_n;
    logic                 restart;
    logic [PRE_LOG_W-1:0] pre_log2;

    assign mode_in  = '{sync_sel: sync_sel, wide_sel: wide_sel, fast_sel: fast_sel};
    assign pre_log2 = prescale_log2(mode_q);

    brg_cfg_regs #(.BYTE_W(BYTE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wr_data  (wr_data),
        .mode_in  (mode_in),
        .div_n    (div_n),
        .mode_q_o (mode_q),
        .restart_o(restart)
    );

    brg_sub_counter #(.DIV_W(DIV_W)) u_sub (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .reload  (div_n),
        .sub_tick(sub_tick)
    );

    brg_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sub_tick (sub_tick),
        .pre_log2 (pre_log2),
        .baud_tick(baud_tick)
    );

    AST_BAUD_NEEDS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> sub_tick); // R11

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!baud_tick && !sub_tick) || rst_n); // R1

endmodule

// File: tb/baud_gen_top_bench.sv
module baud_gen_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_hi = 1'b0;
    logic       wr_lo = 1'b0;
    logic [7:0] wr_data = '0;
    logic       sync_sel = 1'b0;
    logic       wide_sel = 1'b0;
    logic       fast_sel = 1'b0;
    logic       baud_tick;
    logic       sub_tick;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    baud_gen_top u_baud_gen_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wr_data  (wr_data),
        .sync_sel (sync_sel),
        .wide_sel (wide_sel),
        .fast_sel (fast_sel),
        .baud_tick(baud_tick),
        .sub_tick (sub_tick)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Count negedges after the restart edge; offs=1 after a write or mode change
    task automatic measure(int n, int m, int offs, string req, output int period);
        int first_sub = 0;
        int second_sub = 0;
        int first_baud = 0;
        int second_baud = 0;
        int bad_baud = 0;
        int double_baud = 0;
        logic prev_baud = 1'b0;
        int limit = 2 * m * (n + 1) + 8;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (k == 1) begin
                wr_hi = 1'b0;
                wr_lo = 1'b0;
            end
            if (sub_tick) begin
                if (first_sub == 0) first_sub = k;
                else if (second_sub == 0) second_sub = k;
            end
            if (baud_tick && !sub_tick) bad_baud++;
            if (baud_tick && prev_baud) double_baud++;
            prev_baud = baud_tick;
            if (baud_tick) begin
                if (first_baud == 0) begin
                    first_baud = k;
                end else begin
                    second_baud = k;
                    break;
                end
            end
        end
        check_eq({req, "/R8/R10"}, "first sub-tick cycle", first_sub, n + 1 + offs);
        check_eq({req, "/R10"}, "sub-tick spacing", second_sub - first_sub, n + 1);
        check_eq({req, "/R8"}, "first baud-tick cycle", first_baud, m * (n + 1) + offs);
        check_eq(req, "baud period", second_baud - first_baud, m * (n + 1));
        check_eq("R11", "baud without sub-tick", bad_baud, 0);
        check_eq("R11", "baud wider than one cycle", double_baud, 0);
        period = second_baud - first_baud;
    endtask

    task automatic configure(int hi, int lo, bit s, bit w, bit f);
        @(negedge clk);
        sync_sel = s;
        wide_sel = w;
        fast_sel = f;
        wr_hi    = 1'b1;
        wr_data  = 8'(hi);
        @(negedge clk);
        wr_hi    = 1'b0;
        wr_lo    = 1'b1;
        wr_data  = 8'(lo);
        @(posedge clk);
    endtask

    task automatic run_cfg(int hi, int lo, bit s, bit w, bit f, output int period);
        int    n = w ? hi * 256 + lo : lo;
        int    m = s ? 4 : ((w && f) ? 4 : ((w ^ f) ? 16 : 64));
        string req = s ? "R7" : ((w && f) ? "R6" : ((w ^ f) ? "R5" : "R4"));
        if (hi != 0) req = {req, w ? "/R3" : "/R2"};
        configure(hi, lo, s, w, f);
        measure(n, m, 1, req, period);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p;
        int lo_set[5] = '{0, 1, 2, 7, 25};

        // R1: reset quiet, then default divisor 0 in slow narrow mode
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_eq("R1", "baud_tick in reset", int'(baud_tick), 0);
            check_eq("R1", "sub_tick in reset", int'(sub_tick), 0);
        end
        rst_n = 1'b1;
        @(posedge clk);
        measure(0, 64, 0, "R1", p);

        // R2..R7, R10, R11: sweep of modes and divisors
        for (int mode = 0; mode < 8; mode++) begin
            for (int hi = 0; hi < 2; hi++) begin
                for (int li = 0; li < 5; li++) begin
                    run_cfg(hi, lo_set[li], mode[2], mode[1], mode[0], p);
                end
            end
        end

        // R12: 16 MHz, n=25, slow narrow mode gives 9615 per second
        run_cfg(0, 25, 1'b0, 1'b0, 1'b0, p);
        check_eq("R12", "rate at 16 MHz", (p > 0) ? 16000000 / p : 0, 9615);

        // R8: rewrite of an unchanged divisor in mid-period restarts
        run_cfg(0, 9, 1'b0, 1'b0, 1'b1, p);
        repeat (50) @(negedge clk);
        wr_lo   = 1'b1;
        wr_data = 8'd9;
        @(posedge clk);
        measure(9, 16, 1, "R8", p);

        // R9: mode change alone in mid-period restarts with the new factor
        repeat (70) @(negedge clk);
        fast_sel = 1'b0;
        @(posedge clk);
        measure(9, 64, 1, "R9", p);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule